// File: doc/BRIEF.md
# Notched-Carrier Nine-Level PWM Modulator

This block turns a signed reference sample into a nine-level command for a single-phase multilevel inverter. The command is a signed level index from -4 to +4. Each step of the index is a quarter of the DC input voltage. The block compares the reference against four level-shifted carriers stacked above zero and against their mirror images below zero. A carrier that the reference clears adds one level on its side of zero.

The carrier shape is not a plain triangle. Each carrier period is split into four equal quarters:

- In the first quarter the carrier climbs to full scale.
- In the second quarter it drops to a programmable dip level.
- In the third quarter it climbs back to full scale.
- In the fourth quarter it returns to zero.

With the dip at full scale, the middle half of the period is flat at full scale, so the wave is a flat-topped trapezoid that gives a single pulse per period. With the dip at zero, the wave becomes plain symmetric triangles that touch zero at mid-period. Useful settings lie between these two.

The period length in clock cycles and the dip level are taken from their inputs only at a period boundary. A period start strobe marks each new cycle. A system using the nominal 2.5 kHz switching rate sets the period count to the clock rate divided by 2.5 kHz, rounded down to a multiple of four. A modulation index below one is applied by scaling the reference amplitude before it enters.

Top module: `ncpwm_mod`

## Requirements
- R1: With Q the quarter length, quarter index q (0..3), position n (0..Q-1) inside the quarter and dip D, the carrier is B + floor((65535-B)*m/Q). Here B = D for q = 1 or 2 and B = 0 otherwise. The factor m = n in quarters 0 and 2, and m = Q-n in quarters 1 and 3.
- R2: With D = 65535 the carrier holds 65535 through quarters 1 and 2. A reference of 65535 gives level 0 there, and a reference of 65536 gives level 1.
- R3: With D = 0 the carrier falls to zero-terminated slopes in quarters 1 and 2, so the period holds two symmetric triangles. The carrier formula of R1 still applies with B = 0.
- R4: For a reference r >= 0 the level equals the number of bands k in 0..3 with r > k*65536 + c, where c is the current carrier value.
- R5: For r < 0 the level equals minus the number of bands k in 0..3 with r < -(k*65536 + c).
- R6: A reference of exactly zero gives level 0. A reference of +262144 gives +4, and a reference of -262144 gives -4.
- R7: The level output is registered. It reflects the reference and the carrier phase present one clock edge earlier.
- R8: The period strobe is high for exactly one cycle. That cycle follows the clock edge at which the phase wraps from the last position of quarter 3 to quarter 0, so the strobes are 4*Q cycles apart.
- R9: Changes on the period and dip inputs take effect only at the wrap of R8. A change in the middle of a period leaves the rest of that period unchanged.
- R10: While reset is high, and at the first cycle after it, the phase is quarter 0 position 0 and the carrier value is 0. During reset the level is 0 and the strobe is 0. The period and dip are taken from their inputs during reset.
- R11: Q is the period count shifted right by two, so its two low bits are ignored. A result of zero is treated as Q = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W (20) | Signed reference; 65536 per level step |
| per_in | input | PW (16) | Carrier period in clock cycles |
| dq_in | input | CW (16) | Dip level, 0 to 65535 |
| level_o | output | 4 | Signed level index, -4 to +4 |
| strobe_o | output | 1 | One-cycle period start pulse |

## Verification
The bench aims references at the exact band thresholds. A reference of 65535 under a flat top shows whether the comparison is strict: an inclusive comparison would report level 1 there. Zero and the extreme references probe the sign handling, where a design that mirrors the negative bands wrongly outputs nonzero or clipped levels. The period and dip are changed in the middle of a period, so a design that applies them at once would shift the strobe and the carrier. Periods whose two low bits are set, and the degenerate one-cycle quarter, expose a quarter length that is computed wrongly or misses the wrap.

// File: rtl/ncpwm_mod.sv
module ncpwm_mod #(
  parameter int CW    = 16,
  parameter int PW    = 16,
  parameter int REF_W = CW + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic        [PW-1:0]    per_in,
  input  logic        [CW-1:0]    dq_in,
  output logic signed [3:0]       level_o,
  output logic                    strobe_o
);
  localparam int QW = PW - 2;
  localparam int NB = 4;
  localparam logic [CW-1:0] FS = {CW{1'b1}};

  logic [QW-1:0] n_q, qlen, m;
  logic [1:0]    qtr_q;
  logic [PW-1:0] per_l;
  logic [CW-1:0] dq_l, base, span, carr;
  logic [CW+QW-1:0] prod, quot;
  logic last_n, wrap, rising;
  logic [NB-1:0] above, below;
  logic signed [3:0] lvl_d;

  assign qlen   = (per_l[PW-1:2] == '0) ? QW'(1) : per_l[PW-1:2];
  assign last_n = (n_q == qlen - QW'(1));
  assign wrap   = last_n && (qtr_q == 2'd3);
  assign rising = ~qtr_q[0];
  assign base   = (qtr_q[0] ^ qtr_q[1]) ? dq_l : '0;
  assign span   = FS - base;
  assign m      = rising ? n_q : qlen - n_q;
  assign prod   = {{QW{1'b0}}, span} * {{CW{1'b0}}, m};
  assign quot   = prod / {{CW{1'b0}}, qlen};
  assign carr   = base + quot[CW-1:0];

  for (genvar k = 0; k < NB; k++) begin : g_band
    logic signed [REF_W-1:0] th;
    assign th       = REF_W'({2'(k), carr});
    assign above[k] = ref_in > th;
    assign below[k] = ref_in < -th;
  end

  always_comb lvl_d = 4'($countones(above)) - 4'($countones(below));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q      <= '0;
      qtr_q    <= '0;
      per_l    <= per_in;
      dq_l     <= dq_in;
      level_o  <= '0;
      strobe_o <= 1'b0;
    end else begin
      level_o  <= lvl_d;
      strobe_o <= wrap;
      if (last_n) begin
        n_q   <= '0;
        qtr_q <= qtr_q + 2'd1;
      end else begin
        n_q <= n_q + QW'(1);
      end
      if (wrap) begin
        per_l <= per_in;
        dq_l  <= dq_in;
      end
    end
  end

  // R4
  level_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_in >= 0) |=> (level_o >= 0 && level_o <= 4));
  // R5
  level_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_in < 0) |=> (level_o <= 0 && level_o >= -4));
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (n_q == '0 && qtr_q == 2'd0));
  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(per_l) && $stable(dq_l)));
  // R1
  dip_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (qtr_q[0] ^ qtr_q[1]) |-> (carr >= dq_l));
endmodule

// File: tb/ncpwm_mod_tb.sv
module ncpwm_mod_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [19:0] ref_in = '0;
  logic [15:0] per_in = 16'd40;
  logic [15:0] dq_in = 16'd32768;
  logic signed [3:0] level_o;
  logic strobe_o;

  always #10 clk = ~clk;

  ncpwm_mod dut_i (.clk(clk), .rst(rst), .ref_in(ref_in), .per_in(per_in),
                   .dq_in(dq_in), .level_o(level_o), .strobe_o(strobe_o));

  typedef struct { int lvl; bit stb; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int mn, mq, mper, mdq;
  int unsigned lfsr = 32'h1234_5678;

  function automatic int qlen_of(int p);
    return ((p >> 2) == 0) ? 1 : (p >> 2);
  endfunction

  function automatic int carr_m(int n, int qq, int ql, int d);
    int b, s, mm;
    b  = (qq == 1 || qq == 2) ? d : 0;
    s  = 65535 - b;
    mm = (qq == 0 || qq == 2) ? n : ql - n;
    return b + int'((longint'(s) * mm) / ql);
  endfunction

  function automatic int lvl_m(int r, int c);
    int cnt = 0;
    for (int k = 0; k < 4; k++) begin
      if (r > k * 65536 + c) cnt++;
      if (r < -(k * 65536 + c)) cnt--;
    end
    return cnt;
  endfunction

  task automatic step(int r);
    exp_t e;
    int ql;
    ql = qlen_of(mper);
    ref_in = 20'(r);
    e.lvl = lvl_m(r, carr_m(mn, mq, ql, mdq));
    e.stb = (mq == 3 && mn == ql - 1);
    e.tag = (r == 0 || r == 262144 || r == -262144) ? "R6" : (r > 0 ? "R4" : "R5");
    q.push_back(e);
    if (mn == ql - 1) begin
      mn = 0;
      mq = (mq + 1) % 4;
      if (e.stb) begin mper = int'(per_in); mdq = int'(dq_in); end
    end else mn++;
    @(negedge clk);
  endtask

  function automatic int rnd_ref();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr % 524289) - 262144;
  endfunction

  task automatic do_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (level_o !== 4'sd0 || strobe_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs: level=%0d strobe=%0b expected level=0 strobe=0", level_o, strobe_o);
    end
    mn = 0; mq = 0; mper = int'(per_in); mdq = int'(dq_in);
    rst = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks += 2;
      if (int'(level_o) != e.lvl) begin
        errors++;
        $display("FAIL %s level: actual=%0d expected=%0d", e.tag, level_o, e.lvl);
      end
      if (strobe_o != e.stb) begin
        errors++;
        $display("FAIL R8 strobe: actual=%0b expected=%0b", strobe_o, e.stb);
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();                                  // R10
    for (int i = 0; i < 200; i++) step(rnd_ref());   // R1 R4 R5 R7
    for (int i = 0; i < 40; i++) step(0);            // R6
    for (int i = 0; i < 20; i++) step(262144);
    for (int i = 0; i < 20; i++) step(-262144);
    for (int i = 0; i < 15; i++) step(rnd_ref());
    dq_in = 16'd65535;                               // R9 mid-period change, R2
    for (int i = 0; i < 120; i++) step((i % 2) ? 65535 : 65536);
    for (int i = 0; i < 80; i++) step((i % 2) ? -65535 : -65536);
    for (int i = 0; i < 7; i++) step(rnd_ref());
    dq_in = 16'd0;                                   // R3
    for (int i = 0; i < 120; i++) step(rnd_ref());
    for (int i = 0; i < 80; i++) step((i % 2) ? 32768 : -32768);
    per_in = 16'd43;                                 // R11 low bits ignored
    dq_in = 16'd20000;
    for (int i = 0; i < 200; i++) step(rnd_ref());
    per_in = 16'd12;
    for (int i = 0; i < 100; i++) step(rnd_ref());
    do_reset();                                      // R10 mid-run reset
    for (int i = 0; i < 60; i++) step(rnd_ref());
    per_in = 16'd4;                                  // R11 one-cycle quarter
    for (int i = 0; i < 60; i++) step(rnd_ref());
    per_in = 16'd2;                                  // R11 zero quarter treated as one
    for (int i = 0; i < 40; i++) step(rnd_ref());
    repeat (3) @(posedge clk);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule